// File: doc/BRIEF.md
# Cluster Core Barrier Synchroniser

The block parks the cores of one cluster at numbered rendezvous points and wakes them together. Each rendezvous point (a slot) keeps one arrival bit per local core. A core reaches a barrier by presenting an arrival: a slot number, the number of participants it expects, and its global core id. The block folds the global id onto a local core position and marks that core present in the chosen slot. From then on the core is reported as suspended.

Every arrival compares the slot's updated membership against the participant count carried by that same arrival. When the number of marked cores matches the count, the slot releases. Every marked core, the final arriver included, gets a single-cycle wake pulse. The slot is then emptied so its number can be used again. Software on the cores picks the slot numbers and counts. The block only records, compares, wakes and clears.

Top module: `core_barrier_sync`

## Requirements
- R1: After reset every slot is empty, `resume_o` is all zero and `suspended_o` is all zero.
- R2: The local core position is the global core id modulo NUM_CORES. Bit k of `resume_o` and of `suspended_o` belongs to local core k.
- R3: An accepted arrival that does not release its slot raises `suspended_o[k]` for the arriving local core k on the cycle after acceptance. The bit stays high until that core is woken.
- R4: An arrival releases its slot when the number of set bits in the slot mask, with the arriver's bit included, equals `arr_count_i`. One cycle after acceptance, `resume_o` equals that mask for exactly one cycle.
- R5: A release wakes only the cores recorded in the releasing slot. Cores waiting in other slots keep their `suspended_o` bits and get no pulse.
- R6: A release empties its slot, so the woken cores drop out of `suspended_o` in the same cycle as their pulse. A later round on the same slot number starts counting from zero.
- R7: Slots are independent. Arrivals at one slot never change another slot's membership.
- R8: A repeated arrival from a core already marked in the slot leaves the mask unchanged, so it does not raise the membership count.
- R9: An arrival with `arr_count_i` equal to 0 never releases.
- R10: In a cycle without an accepted arrival, `resume_o` is zero on the following cycle and `suspended_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all slots |
| arr_valid_i | input | 1 | An arrival is presented this cycle |
| arr_slot_i | input | SLOT_W | Barrier slot number |
| arr_count_i | input | CNT_W | Expected participant count for this arrival |
| arr_core_i | input | GCORE_W | Global id of the arriving core |
| resume_o | output | NUM_CORES | One-cycle wake pulse per local core |
| suspended_o | output | NUM_CORES | Core is waiting in some slot |

## Verification
The bench builds the block with NUM_CORES = 3, NUM_SLOTS = 2 and a 6-bit global id. A core count that is not a power of two makes the modulo fold a real division. Global ids such as 4, 5 and 8 then land on positions different from their low bits. Two slots are enough to hold one core waiting in one slot while another slot releases. The 2-bit count field covers zero, partial counts and the full cluster. With only three cores, full releases, partial releases and repeated arrivals each take only a handful of cycles.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    typedef enum logic {
        EV_HOLD    = 1'b0,
        EV_RELEASE = 1'b1
    } bar_event_e;
endpackage

// File: rtl/bar_local_index.sv
module bar_local_index #(
    parameter int GCORE_W   = 8,
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [GCORE_W-1:0] core_i,
    output logic [IDX_W-1:0]   idx_o
);
    logic [GCORE_W-1:0] rem;

    always_comb begin
        rem   = core_i % GCORE_W'(NUM_CORES);
        idx_o = rem[IDX_W-1:0];
    end
endmodule

// File: rtl/bar_popcount.sv
module bar_popcount #(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    logic [N:0][CW-1:0] part;

    assign part[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_acc
        assign part[i+1] = part[i] + CW'(vec_i[i]);
    end
    assign cnt_o = part[N];
endmodule

// File: rtl/bar_mask_merge.sv
module bar_mask_merge #(
    parameter int N = 4,
    parameter int S = 4
) (
    input  logic [S-1:0][N-1:0] masks_i,
    output logic [N-1:0]        any_o
);
    logic [S:0][N-1:0] part;

    assign part[0] = '0;
    for (genvar s = 0; s < S; s++) begin : g_or
        assign part[s+1] = part[s] | masks_i[s];
    end
    assign any_o = part[S];
endmodule

// File: rtl/core_barrier_sync.sv
module core_barrier_sync #(
    parameter int NUM_CORES = 4,
    parameter int NUM_SLOTS = 4,
    parameter int GCORE_W   = 8,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W    = $clog2(NUM_CORES + 1),
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arr_valid_i,
    input  logic [SLOT_W-1:0]    arr_slot_i,
    input  logic [CNT_W-1:0]     arr_count_i,
    input  logic [GCORE_W-1:0]   arr_core_i,
    output logic [NUM_CORES-1:0] resume_o,
    output logic [NUM_CORES-1:0] suspended_o
);
    import barrier_pkg::*;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][NUM_CORES-1:0] mask;
        logic [NUM_CORES-1:0]                wake;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0]     local_idx;
    logic [NUM_CORES-1:0] arr_bit;
    logic [NUM_CORES-1:0] merged;
    logic [CNT_W-1:0]     member_cnt;
    logic                 slot_ok;
    bar_event_e           evt;

    bar_local_index #(
        .GCORE_W  (GCORE_W),
        .NUM_CORES(NUM_CORES),
        .IDX_W    (IDX_W)
    ) u_idx (
        .core_i(arr_core_i),
        .idx_o (local_idx)
    );

    always_comb begin
        arr_bit = '0;
        arr_bit[local_idx] = 1'b1;
        slot_ok = (32'(arr_slot_i) < NUM_SLOTS);
        merged  = slot_ok ? (state_q.mask[arr_slot_i] | arr_bit) : '0;
    end

    bar_popcount #(
        .N (NUM_CORES),
        .CW(CNT_W)
    ) u_pop (
        .vec_i(merged),
        .cnt_o(member_cnt)
    );

    always_comb begin
        evt = (member_cnt == arr_count_i) ? EV_RELEASE : EV_HOLD;
        state_d      = state_q;
        state_d.wake = '0;
        if (arr_valid_i && slot_ok) begin
            if (evt == EV_RELEASE) begin
                state_d.wake             = merged;
                state_d.mask[arr_slot_i] = '0;
            end else begin
                state_d.mask[arr_slot_i] = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    bar_mask_merge #(
        .N(NUM_CORES),
        .S(NUM_SLOTS)
    ) u_merge (
        .masks_i(state_q.mask),
        .any_o  (suspended_o)
    );

    assign resume_o = state_q.wake;
endmodule

// File: rtl/core_barrier_sync_chk.sv
module core_barrier_sync_chk #(
    parameter int NUM_CORES = 4,
    parameter int GCORE_W   = 8,
    parameter int CNT_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 arr_valid_i,
    input logic [CNT_W-1:0]     arr_count_i,
    input logic [GCORE_W-1:0]   arr_core_i,
    input logic [NUM_CORES-1:0] resume_o,
    input logic [NUM_CORES-1:0] suspended_o
);
    logic [GCORE_W-1:0]   prev_pos;
    logic [NUM_CORES-1:0] prev_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_pos <= '0;
        else        prev_pos <= arr_core_i % GCORE_W'(NUM_CORES);
    end

    always_comb begin
        prev_bit = '0;
        for (int k = 0; k < NUM_CORES; k++)
            if (32'(prev_pos) == k) prev_bit[k] = 1'b1;
    end

    // R3
    arrive_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid_i |=> ((suspended_o | resume_o) & prev_bit) != '0);

    // R5
    wake_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid_i |=> (resume_o & ~($past(suspended_o) | prev_bit)) == '0);

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid_i && arr_count_i == '0) |=> resume_o == '0);

    // R10
    idle_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid_i |=> resume_o == '0);

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid_i |=> $stable(suspended_o));
endmodule

bind core_barrier_sync core_barrier_sync_chk #(
    .NUM_CORES(NUM_CORES),
    .GCORE_W  (GCORE_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_valid_i(arr_valid_i),
    .arr_count_i(arr_count_i),
    .arr_core_i (arr_core_i),
    .resume_o   (resume_o),
    .suspended_o(suspended_o)
);

// File: tb/core_barrier_sync_bench.sv
module core_barrier_sync_bench;
    localparam int NC = 3;
    localparam int NS = 2;
    localparam int GW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arr_valid_i = 1'b0;
    logic [0:0]    arr_slot_i = '0;
    logic [1:0]    arr_count_i = '0;
    logic [GW-1:0] arr_core_i = '0;
    logic [NC-1:0] resume_o;
    logic [NC-1:0] suspended_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    core_barrier_sync #(
        .NUM_CORES(NC),
        .NUM_SLOTS(NS),
        .GCORE_W  (GW)
    ) u_core_barrier_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .arr_valid_i(arr_valid_i),
        .arr_slot_i (arr_slot_i),
        .arr_count_i(arr_count_i),
        .arr_core_i (arr_core_i),
        .resume_o   (resume_o),
        .suspended_o(suspended_o)
    );

    task automatic check(string req, logic [NC-1:0] res_exp, logic [NC-1:0] sus_exp);
        tests++;
        if (resume_o !== res_exp || suspended_o !== sus_exp) begin
            fails++;
            $display("FAIL %s: resume=%b suspended=%b expected resume=%b suspended=%b",
                     req, resume_o, suspended_o, res_exp, sus_exp);
        end
    endtask

    // drive at a falling edge, accepted at the next rising edge, sampled at the falling edge after
    task automatic arrive(int slot, int cnt, int core);
        @(negedge clk);
        arr_valid_i = 1'b1;
        arr_slot_i  = 1'(slot);
        arr_count_i = 2'(cnt);
        arr_core_i  = GW'(core);
        @(negedge clk);
        arr_valid_i = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset", 3'b000, 3'b000);
    endtask

    task automatic t_full_round();
        arrive(0, 3, 0);
        check("R3 first arrival", 3'b000, 3'b001);
        arrive(0, 3, 4);
        check("R2 id 4 folds to core 1", 3'b000, 3'b011);
        arrive(0, 3, 8);
        check("R4 full release", 3'b111, 3'b000);
        idle_cycle();
        check("R4 single-cycle pulse", 3'b000, 3'b000);
    endtask

    task automatic t_reuse();
        arrive(0, 2, 1);
        check("R6 reuse starts empty", 3'b000, 3'b010);
        arrive(0, 2, 2);
        check("R6 reuse releases", 3'b110, 3'b000);
        idle_cycle();
    endtask

    task automatic t_subset();
        arrive(1, 2, 0);
        arrive(1, 2, 2);
        check("R5 only recorded cores", 3'b101, 3'b000);
        idle_cycle();
    endtask

    task automatic t_independent();
        arrive(0, 2, 0);
        arrive(1, 1, 1);
        check("R7 other slot releases alone", 3'b010, 3'b001);
        arrive(0, 2, 5);
        check("R7 slot 0 unaffected then releases", 3'b101, 3'b000);
        idle_cycle();
    endtask

    task automatic t_duplicate();
        arrive(0, 2, 1);
        arrive(0, 2, 1);
        check("R8 repeat does not count", 3'b000, 3'b010);
        arrive(0, 2, 3);
        check("R8 release after repeat", 3'b011, 3'b000);
        idle_cycle();
    endtask

    task automatic t_zero_count();
        arrive(1, 0, 2);
        check("R9 zero count holds", 3'b000, 3'b100);
        arrive(1, 2, 0);
        check("R9 later release", 3'b101, 3'b000);
        idle_cycle();
    endtask

    task automatic t_idle();
        arrive(0, 3, 2);
        idle_cycle();
        check("R10 idle keeps state", 3'b000, 3'b100);
        idle_cycle();
        idle_cycle();
        check("R10 idle no pulse", 3'b000, 3'b100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle_cycle();
        t_reset();
        t_full_round();
        t_reuse();
        t_subset();
        t_independent();
        t_duplicate();
        t_zero_count();
        t_idle();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule